// File: doc/BRIEF.md
# Serial Transmit Frame Reference Generator

This block turns an external bit-rate clock into a set of timing references that a payload multiplexer outside the block uses to assemble a serial E2 or E3 frame. Each clock cycle stands for one bit position of the frame. The block walks through the frame and marks three things. It marks the first bit of the frame with an active-low start pulse. It marks every overhead position (framing word plus service bits) with an active-low gap marker. It also drives a reference bit stream that carries the framing word and is zero everywhere else. The input clock is passed through to a clock output.

A 2-bit format select picks one of four frame formats. The two lower codes are the 8448 kbit/s formats and the two upper codes are the 34368 kbit/s formats. A new format is taken only at a frame boundary, so a frame that has started always runs to its full length. The generator runs only while the terminal side is in bit-serial mode. When serial mode is off, the outputs rest in their idle state and the frame position returns to the start.

Top module: `txref_gen`

## Requirements
- R1: While reset (rst_n low) is applied, ref_frame_n and ref_gap_n are 1 and ref_data is 0.
- R2: While serial_en is low, the registered outputs are idle (ref_frame_n=1, ref_gap_n=1, ref_data=0) one cycle later. On the first enabled cycle the position restarts at frame bit 1.
- R3: ref_frame_n is 0 for exactly one cycle per frame, on frame bit 1.
- R4: ref_data is 1 only where the framing word 1111010000 has a 1, in frame bits 1 to 10 (bit 1 is the leftmost digit). It is 0 at every other bit position.
- R5: ref_gap_n is 0 on frame bits 1 to 12 (10 framing bits, then 2 service bits) and 1 on all other bits.
- R6: With fmt_sel 00 or 01 (8448 kbit/s formats) the frame is 848 bits long.
- R7: With fmt_sel 10 or 11 (34368 kbit/s formats) the frame is 1536 bits long.
- R8: A change of fmt_sel takes effect only at the next frame boundary. The current frame keeps its length.
- R9: ref_clk equals clk while serial_en is 1 and is held at 0 while serial_en is 0.
- R10: The marker outputs are registered. The value for a bit position appears one clock after the edge at which the counter held that position. The first enabled edge therefore gives frame bit 1 on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one cycle per frame bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_en | input | 1 | High when the terminal side is in bit-serial mode |
| fmt_sel | input | 2 | Frame format select (00/01: 848-bit frame, 10/11: 1536-bit frame) |
| ref_clk | output | 1 | Pass-through clock, gated low when disabled |
| ref_frame_n | output | 1 | Active-low pulse on frame bit 1 |
| ref_gap_n | output | 1 | Active-low over framing and service bits |
| ref_data | output | 1 | Framing word at its positions, zero elsewhere |

## Verification
Two events can land on the same edge. One is a format change: fmt_sel can move on the very cycle the counter sits on the last bit of a frame. The other is disabling the block at that same point. The bench drives fmt_sel exactly on the last-bit cycle, one cycle before it, and one cycle after the wrap. For each case it judges whether the new length applies to the frame that follows or one frame later. It also drops serial_en in the middle of a frame and expects idle outputs, then a restart at frame bit 1.

// File: rtl/txref_pkg.sv
package txref_pkg;

    typedef struct packed {
        logic frame_n;
        logic gap_n;
        logic data;
    } ref_out_t;

    localparam ref_out_t REF_IDLE = '{frame_n: 1'b1, gap_n: 1'b1, data: 1'b0};

endpackage

// File: rtl/txref_pos_counter.sv
module txref_pos_counter #(
    parameter int LEN_F0 = 848,
    parameter int LEN_F1 = 848,
    parameter int LEN_F2 = 1536,
    parameter int LEN_F3 = 1536,
    parameter int CW     = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    fmt_sel,
    output logic [CW-1:0] pos,
    output logic [1:0]    fmt_cur
);

    localparam logic [CW-1:0] LAST0 = CW'(LEN_F0 - 1);
    localparam logic [CW-1:0] LAST1 = CW'(LEN_F1 - 1);
    localparam logic [CW-1:0] LAST2 = CW'(LEN_F2 - 1);
    localparam logic [CW-1:0] LAST3 = CW'(LEN_F3 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    fmt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW-1:0] last_pos;

    always_comb begin
        case (st_q.fmt)
            2'd0:    last_pos = LAST0;
            2'd1:    last_pos = LAST1;
            2'd2:    last_pos = LAST2;
            default: last_pos = LAST3;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.fmt = fmt_sel;
        end else if (st_q.cnt == last_pos) begin
            st_d.cnt = '0;
            st_d.fmt = fmt_sel;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, fmt: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos     = st_q.cnt;
    assign fmt_cur = st_q.fmt;

    // Position never leaves the frame of the format in force (R6, R7)
    assert_pos_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_pos);

    // Format is only swapped when the position is back at the start
    assert_fmt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> $stable(st_q.fmt));

endmodule

// File: rtl/txref_decode.sv
module txref_decode #(
    parameter int                 CW      = 11,
    parameter int                 FAS_LEN = 10,
    parameter logic [FAS_LEN-1:0] FAS_PAT = 10'b1111010000,
    parameter int                 OVH_LEN = 12
) (
    input  logic [CW-1:0] pos,
    output logic          at_start,
    output logic          fas_one,
    output logic          in_ovh
);

    localparam logic [CW-1:0] OVH_END = CW'(OVH_LEN);

    logic [FAS_LEN-1:0] hit;

    // One comparator per framing bit; bit 1 of the frame is the MSB of the word
    for (genvar i = 0; i < FAS_LEN; i++) begin : g_fas
        assign hit[i] = (pos == CW'(i)) && FAS_PAT[FAS_LEN-1-i];
    end

    assign at_start = (pos == '0);
    assign fas_one  = |hit;
    assign in_ovh   = (pos < OVH_END);

endmodule

// File: rtl/txref_gen.sv
module txref_gen
    import txref_pkg::*;
#(
    parameter int LEN_F0  = 848,
    parameter int LEN_F1  = 848,
    parameter int LEN_F2  = 1536,
    parameter int LEN_F3  = 1536,
    parameter int FAS_LEN = 10,
    parameter int OVH_LEN = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_en,
    input  logic [1:0] fmt_sel,
    output logic       ref_clk,
    output logic       ref_frame_n,
    output logic       ref_gap_n,
    output logic       ref_data
);

    localparam int LEN_A  = (LEN_F0 > LEN_F1) ? LEN_F0 : LEN_F1;
    localparam int LEN_B  = (LEN_F2 > LEN_F3) ? LEN_F2 : LEN_F3;
    localparam int LEN_MX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CW     = $clog2(LEN_MX);

    logic [CW-1:0] pos;
    logic [1:0]    fmt_cur;
    logic          at_start, fas_one, in_ovh;
    ref_out_t      out_d, out_q;

    txref_pos_counter #(
        .LEN_F0(LEN_F0), .LEN_F1(LEN_F1), .LEN_F2(LEN_F2), .LEN_F3(LEN_F3), .CW(CW)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (serial_en),
        .fmt_sel(fmt_sel),
        .pos    (pos),
        .fmt_cur(fmt_cur)
    );

    txref_decode #(
        .CW(CW), .FAS_LEN(FAS_LEN), .FAS_PAT(10'b1111010000), .OVH_LEN(OVH_LEN)
    ) u_dec (
        .pos     (pos),
        .at_start(at_start),
        .fas_one (fas_one),
        .in_ovh  (in_ovh)
    );

    always_comb begin
        out_d = REF_IDLE;
        if (serial_en) begin
            out_d.frame_n = !at_start;
            out_d.gap_n   = !in_ovh;
            out_d.data    = fas_one;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= REF_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign ref_clk     = clk & serial_en;
    assign ref_frame_n = out_q.frame_n;
    assign ref_gap_n   = out_q.gap_n;
    assign ref_data    = out_q.data;

    // Start of frame is inside the overhead window
    assert_start_in_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_frame_n |-> !ref_gap_n);

    // Framing ones only appear under the gap marker
    assert_data_in_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_data |-> !ref_gap_n);

    // Start pulse lasts a single bit
    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_frame_n |=> ref_frame_n);

    // Disabled generator rests idle one cycle later
    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_en |=> (ref_frame_n && ref_gap_n && !ref_data));

    // Output path follows the counter position by one register
    assert_start_follows_pos_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_en && pos == '0) |=> !ref_frame_n);

    // fmt_cur is only observed through the counter; keep it referenced
    assert_fmt_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(fmt_cur));

endmodule

// File: tb/txref_gen_test.sv
module txref_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam string FAS = "1111010000";

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_en = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       ref_clk, ref_frame_n, ref_gap_n, ref_data;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int  m_pos = 0;
    int  m_len = 848;
    int  m_cur_len = 848;
    bit  e_frame_n = 1, e_gap_n = 1, e_data = 0;
    int  pulse_len = 0;
    int  prev_len = 0;
    bit  have_prev = 0;
    int  spacing = 0;
    bit  fmt_moved = 0;

    txref_gen uut (
        .clk(clk), .rst_n(rst_n), .serial_en(serial_en), .fmt_sel(fmt_sel),
        .ref_clk(ref_clk), .ref_frame_n(ref_frame_n), .ref_gap_n(ref_gap_n),
        .ref_data(ref_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int len_of(input logic [1:0] m);
        return m[1] ? 1536 : 848;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Reference model: advances at every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_frame_n = 1; e_gap_n = 1; e_data = 0;
            m_pos = 0; m_len = len_of(fmt_sel);
        end else if (!serial_en) begin
            e_frame_n = 1; e_gap_n = 1; e_data = 0;
            m_pos = 0; m_len = len_of(fmt_sel);
        end else begin
            e_frame_n = (m_pos != 0);
            e_gap_n   = (m_pos >= 12);
            e_data    = (m_pos < 10) ? (FAS[m_pos] == "1") : 1'b0;
            if (m_pos == 0) m_cur_len = m_len;
            if (m_pos == m_len - 1) begin
                m_pos = 0;
                m_len = len_of(fmt_sel);
            end else begin
                m_pos++;
            end
        end
    end

    // Pass-through clock check while clk is high (R9)
    always @(posedge clk) begin
        #1;
        check(serial_en ? "R9 clock pass" : "R9 clock gated", ref_clk, serial_en);
    end

    // Output comparison away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 frame_n in reset", ref_frame_n, 1'b1);
            check("R1 gap_n in reset", ref_gap_n, 1'b1);
            check("R1 data in reset", ref_data, 1'b0);
        end else begin
            check(serial_en ? "R3/R10 frame_n" : "R2 frame_n idle", ref_frame_n, e_frame_n);
            check(serial_en ? "R5 gap_n" : "R2 gap_n idle", ref_gap_n, e_gap_n);
            check(serial_en ? "R4 data" : "R2 data idle", ref_data, e_data);
            // frame spacing measured on the observed pulses
            spacing++;
            if (ref_frame_n === 1'b0) begin
                if (have_prev) begin
                    if (fmt_moved)
                        check_int("R8 frame kept length", spacing, prev_len);
                    else if (prev_len == 848)
                        check_int("R6 frame length", spacing, prev_len);
                    else
                        check_int("R7 frame length", spacing, prev_len);
                end
                have_prev = 1;
                prev_len  = m_cur_len;
                spacing   = 0;
                fmt_moved = 0;
            end
            if (ref_gap_n === 1'b1 && ref_frame_n === 1'b1 && !serial_en) have_prev = 0;
        end
    end

    task automatic wait_pos(input int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    task automatic set_fmt(input logic [1:0] f);
        if (f != fmt_sel && m_pos != 0) fmt_moved = 1;
        fmt_sel = f;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);          // R2: idle while disabled
        serial_en = 1'b1;                    // R10: first bit right after enable
        repeat (3 * 848) @(negedge clk);     // R6 with format 00
        set_fmt(2'b01);
        repeat (2 * 848) @(negedge clk);
        wait_pos(300);                       // R8: change mid-frame
        set_fmt(2'b10);
        repeat (3 * 1536) @(negedge clk);    // R7
        wait_pos(1535);                      // change on the last bit
        set_fmt(2'b00);
        repeat (2 * 848 + 10) @(negedge clk);
        wait_pos(846);                       // change one bit before the last
        set_fmt(2'b11);
        repeat (2 * 1536) @(negedge clk);
        wait_pos(1);                         // change just after the wrap
        set_fmt(2'b00);
        repeat (1536 + 848 + 5) @(negedge clk);
        wait_pos(400);                       // R2: disable mid-frame
        serial_en = 1'b0;
        repeat (20) @(negedge clk);
        fmt_sel = 2'b10;
        repeat (2) @(negedge clk);
        serial_en = 1'b1;                    // restart at frame bit 1
        repeat (2 * 1536 + 5) @(negedge clk);
        wait_pos(0);                         // disable exactly at the boundary
        serial_en = 1'b0;
        repeat (4) @(negedge clk);
        serial_en = 1'b1;
        repeat (900) @(negedge clk);
        rst_n = 1'b0;                        // R1: reset in the middle of a frame
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule